// File: doc/BRIEF.md
# Interleaved Line Refill Memory

This block models the memory side of a cache-line refill. The memory holds words in four one-word-wide banks. A word sits in the bank given by the low-order bits of its word address. A requester presents a line address on a valid/ready port. After the request is accepted, the block returns the four words of that line, lowest first, as single-cycle pulses on a one-word response stream. A last flag marks the final word.

Two timing modes are selected per request.

- **Interleaved mode:** the line address goes to every bank in one address phase. All banks then run their accesses together, so only the word transfers on the shared bus follow one another. A refill takes 4 + 24 + 4×4 = 44 clocks with the default latencies.
- **Serial mode:** one bank is used at a time. The full address, access and transfer sequence repeats for each word, which takes 4 × (4 + 24 + 4) = 128 clocks.

The address, access and transfer latencies are parameters.

The block holds one request at a time. Bank contents are generated from the word address, so the model needs no storage array.

Top module: `ilv_line_fetch`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` and `rsp_last` are 0.
- R2: A request is accepted at a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after that edge through the cycle in which the last word is presented. It is 1 again in the following cycle.
- R3: Word k (k = 0..3) of a line L has word address wa = 4·L + k, so bank k holds it. Its data is {~wa[15:0], wa[15:0]}, with wa placed in bits 15:0 and its complement in bits 31:16. Words are presented in order k = 0, 1, 2, 3.
- R4: In interleaved mode (`mode_serial` = 0 at acceptance), word k is presented in the cycle that ends at rising edge A + C + (k+1)·X after the acceptance edge. A = 4 (address), C = 24 (access) and X = 4 (transfer). The last word therefore completes 44 clocks after acceptance.
- R5: In serial mode (`mode_serial` = 1 at acceptance), word k is presented in the cycle that ends at edge (k+1)·(A + C + X) after acceptance. The last word therefore completes 128 clocks after acceptance.
- R6: Each request produces exactly four `rsp_valid` pulses of one cycle each. `rsp_last` is 1 only together with the fourth pulse.
- R7: `mode_serial` is sampled only at acceptance. Changing it during a refill has no effect on timing.
- R8: `req_line` is sampled only at acceptance. Changing it during a refill has no effect on the returned data.
- R9: A request that is held valid during a refill is accepted at the edge right after the cycle in which the last word was presented. With the default latencies this is 45 clocks after the previous acceptance in interleaved mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_serial | input | 1 | 1 = one bank at a time, 0 = interleaved; sampled at acceptance |
| req_valid | input | 1 | Line request present |
| req_ready | output | 1 | Block is idle and can take a request |
| req_line | input | 14 | Line address |
| rsp_valid | output | 1 | One response word is present this cycle |
| rsp_data | output | 32 | Response word |
| rsp_last | output | 1 | This word is the fourth word of the line |

## Verification
The bound checker tests the following on every cycle:

- the ready/response exclusion and the reopening of `req_ready` after the last word;
- the position of the last flag;
- the data of every word against its word address;
- the acceptance-to-word delay in both modes, measured with its own counter.

Only the bench scenarios can show that a mode or line change in mid-refill has no effect, that a held request is taken back-to-back, and that the total refill takes 44 and 128 clocks. The bench shows these by comparing against a behavioural reference on every clock.

// File: rtl/ilv_pkg.sv
// Package: shared types for the interleaved line refill memory.
// Assumes: nothing beyond standard SystemVerilog.
package ilv_pkg;

    // Sequencer phases of one refill.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_ACC  = 2'd2,
        PH_XFER = 2'd3
    } phase_e;

endpackage

// File: rtl/ilv_bank.sv
// Module: one word-wide memory bank.
// A start pulse captures the line address. After ACCESS_CYC clocks, fin is
// high for one cycle and the word is latched into data, where it stays
// until the next start. The word content is a function of the word
// address {line, BANK_IDX}: the address in the low half, its complement
// in the high half.
// Assumes: ACCESS_CYC >= 1 and WORD_W == 2*(LINE_W+BANK_W).
module ilv_bank #(
    parameter int LINE_W     = 14,
    parameter int BANK_W     = 2,
    parameter int BANK_IDX   = 0,
    parameter int WORD_W     = 32,
    parameter int ACCESS_CYC = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LINE_W-1:0] line,
    output logic              fin,
    output logic [WORD_W-1:0] data
);
    localparam int WA_W  = LINE_W + BANK_W;
    localparam int CNT_W = $clog2(ACCESS_CYC + 1);

    logic              busy;
    logic [CNT_W-1:0]  cnt;
    logic [LINE_W-1:0] line_q;
    logic [WA_W-1:0]   wa;

    assign wa  = {line_q, BANK_W'(BANK_IDX)};
    assign fin = busy && (cnt == '0);

    // Access timer: count down the access time and latch the word when it ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt    <= '0;
            line_q <= '0;
            data   <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            cnt    <= CNT_W'(ACCESS_CYC - 1);
            line_q <= line;
        end else if (busy) begin
            if (cnt == '0) begin
                busy <= 1'b0;
                data <= {~wa, wa};
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/ilv_seq.sv
// Module: refill sequencer.
// Accepts one line request, runs the address phase, starts the banks and
// waits for them, then times each word transfer on the shared bus.
// Interleaved mode starts all banks once. Serial mode repeats the address,
// access and transfer sequence for each bank in turn.
// Assumes: ADDR_CYC >= 1, XFER_CYC >= 1, NUM_BANKS a power of two.
module ilv_seq
    import ilv_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2,
    parameter int LINE_W    = 14,
    parameter int ADDR_CYC  = 4,
    parameter int XFER_CYC  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [LINE_W-1:0]    req_line,
    input  logic                 mode_serial,
    input  logic [NUM_BANKS-1:0] bank_fin,
    output logic                 req_ready,
    output logic [NUM_BANKS-1:0] bank_start,
    output logic [LINE_W-1:0]    line_q,
    output logic [BANK_W-1:0]    word_idx,
    output logic                 beat,
    output logic                 beat_last
);
    localparam int MAX_CYC = (ADDR_CYC > XFER_CYC) ? ADDR_CYC : XFER_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [BANK_W-1:0] LAST_W = BANK_W'(NUM_BANKS - 1);

    phase_e               phase;
    logic [CNT_W-1:0]     cnt;
    logic                 serial_q;
    logic [NUM_BANKS-1:0] mask;
    logic                 accept;
    logic                 acc_done;

    assign accept    = req_valid && (phase == PH_IDLE);
    assign req_ready = (phase == PH_IDLE);

    // Banks taking part in the current access: one in serial mode, all otherwise.
    always_comb begin
        mask = '0;
        if (serial_q) mask[word_idx] = 1'b1;
        else          mask = '1;
    end

    // Bank start at the end of the address phase, done when every started bank finishes.
    assign bank_start = (phase == PH_ADDR && cnt == '0) ? mask : '0;
    assign acc_done   = (phase == PH_ACC) && ((bank_fin & mask) == mask);
    assign beat       = (phase == PH_XFER) && (cnt == '0);
    assign beat_last  = beat && (word_idx == LAST_W);

    // Phase sequencing with a shared down-counter for the address and transfer phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            serial_q <= 1'b0;
            line_q   <= '0;
            word_idx <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        phase    <= PH_ADDR;
                        cnt      <= CNT_W'(ADDR_CYC - 1);
                        serial_q <= mode_serial;
                        line_q   <= req_line;
                        word_idx <= '0;
                    end
                end
                PH_ADDR: begin
                    if (cnt == '0) phase <= PH_ACC;
                    else           cnt   <= cnt - 1'b1;
                end
                PH_ACC: begin
                    if (acc_done) begin
                        phase <= PH_XFER;
                        cnt   <= CNT_W'(XFER_CYC - 1);
                    end
                end
                PH_XFER: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (word_idx == LAST_W) begin
                        phase <= PH_IDLE;
                    end else begin
                        word_idx <= word_idx + 1'b1;
                        if (serial_q) begin
                            phase <= PH_ADDR;
                            cnt   <= CNT_W'(ADDR_CYC - 1);
                        end else begin
                            cnt   <= CNT_W'(XFER_CYC - 1);
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ilv_resp.sv
// Module: response word stage.
// Selects the held word of the bank named by word_idx onto the shared
// one-word bus when a transfer completes, and flags the final word.
// The bus is zero when no word is presented.
// Assumes: bank data is stable while its word is transferred.
module ilv_resp #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2,
    parameter int WORD_W    = 32
) (
    input  logic                              beat,
    input  logic                              beat_last,
    input  logic [BANK_W-1:0]                 word_idx,
    input  logic [NUM_BANKS-1:0][WORD_W-1:0]  bank_data,
    output logic                              rsp_valid,
    output logic [WORD_W-1:0]                 rsp_data,
    output logic                              rsp_last
);
    logic [NUM_BANKS-1:0][WORD_W-1:0] gated;

    // Enable only the addressed bank's word, then OR the words onto the bus.
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_gate
        assign gated[g] = (beat && word_idx == BANK_W'(g)) ? bank_data[g] : '0;
    end

    // Combine the gated bank words.
    always_comb begin
        rsp_data = '0;
        for (int i = 0; i < NUM_BANKS; i++) rsp_data = rsp_data | gated[i];
    end

    assign rsp_valid = beat;
    assign rsp_last  = beat_last;
endmodule

// File: rtl/ilv_line_fetch.sv
// Module: interleaved line refill memory (top).
// Connects the sequencer, NUM_BANKS word-wide banks and the response stage.
// One request is outstanding at a time and the response has no backpressure.
// Assumes: all latency parameters >= 1, NUM_BANKS a power of two >= 2.
module ilv_line_fetch #(
    parameter int LINE_W     = 14,
    parameter int NUM_BANKS  = 4,
    parameter int ADDR_CYC   = 4,
    parameter int ACCESS_CYC = 24,
    parameter int XFER_CYC   = 4,
    parameter int BANK_W     = $clog2(NUM_BANKS),
    parameter int WORD_W     = 2 * (LINE_W + BANK_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_serial,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [LINE_W-1:0] req_line,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data,
    output logic              rsp_last
);
    logic [NUM_BANKS-1:0]             bank_start;
    logic [NUM_BANKS-1:0]             bank_fin;
    logic [NUM_BANKS-1:0][WORD_W-1:0] bank_data;
    logic [LINE_W-1:0]                line_q;
    logic [BANK_W-1:0]                word_idx;
    logic                             beat;
    logic                             beat_last;

    ilv_seq #(
        .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .LINE_W(LINE_W),
        .ADDR_CYC(ADDR_CYC), .XFER_CYC(XFER_CYC)
    ) i_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_line(req_line),
        .mode_serial(mode_serial), .bank_fin(bank_fin), .req_ready(req_ready),
        .bank_start(bank_start), .line_q(line_q), .word_idx(word_idx),
        .beat(beat), .beat_last(beat_last)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        ilv_bank #(
            .LINE_W(LINE_W), .BANK_W(BANK_W), .BANK_IDX(g),
            .WORD_W(WORD_W), .ACCESS_CYC(ACCESS_CYC)
        ) i_bank (
            .clk(clk), .rst_n(rst_n), .start(bank_start[g]), .line(line_q),
            .fin(bank_fin[g]), .data(bank_data[g])
        );
    end

    ilv_resp #(
        .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .WORD_W(WORD_W)
    ) i_resp (
        .beat(beat), .beat_last(beat_last), .word_idx(word_idx),
        .bank_data(bank_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_last(rsp_last)
    );
endmodule

// File: rtl/ilv_line_fetch_chk.sv
// Module: protocol and timing checker bound to ilv_line_fetch.
// Tracks acceptance through the ports only, counts clocks and words since
// acceptance, and checks handshake, ordering, data and per-mode timing.
// Assumes: the default parameters are small enough for an int counter.
module ilv_line_fetch_chk #(
    parameter int LINE_W     = 14,
    parameter int NUM_BANKS  = 4,
    parameter int ADDR_CYC   = 4,
    parameter int ACCESS_CYC = 24,
    parameter int XFER_CYC   = 4,
    parameter int BANK_W     = 2,
    parameter int WORD_W     = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_serial,
    input logic              req_valid,
    input logic              req_ready,
    input logic [LINE_W-1:0] req_line,
    input logic              rsp_valid,
    input logic [WORD_W-1:0] rsp_data,
    input logic              rsp_last
);
    localparam int WA_W = LINE_W + BANK_W;

    logic              acc_mode;
    logic [LINE_W-1:0] acc_line;
    int                elapsed;
    int                seen;
    logic [WA_W-1:0]   exp_wa;
    int                exp_int;
    int                exp_ser;

    assign exp_wa  = {acc_line, BANK_W'(seen)};
    assign exp_int = ADDR_CYC + ACCESS_CYC + (seen + 1) * XFER_CYC - 1;
    assign exp_ser = (seen + 1) * (ADDR_CYC + ACCESS_CYC + XFER_CYC) - 1;

    // Observe acceptance and count clocks and words since it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_mode <= 1'b0;
            acc_line <= '0;
            elapsed  <= 0;
            seen     <= 0;
        end else if (req_valid && req_ready) begin
            acc_mode <= mode_serial;
            acc_line <= req_line;
            elapsed  <= 0;
            seen     <= 0;
        end else begin
            elapsed <= elapsed + 1;
            if (rsp_valid) seen <= seen + 1;
        end
    end

    assert_ready_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
    assert_accept_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    assert_reopen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |=> req_ready);
    assert_last_pos_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_last == (seen == NUM_BANKS - 1)));
    assert_last_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |-> rsp_valid);
    assert_word_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_data == {~exp_wa, exp_wa}));
    assert_time_ilv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !acc_mode) |-> (elapsed == exp_int));
    assert_time_ser_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && acc_mode) |-> (elapsed == exp_ser));
endmodule

bind ilv_line_fetch ilv_line_fetch_chk #(
    .LINE_W(LINE_W), .NUM_BANKS(NUM_BANKS), .ADDR_CYC(ADDR_CYC),
    .ACCESS_CYC(ACCESS_CYC), .XFER_CYC(XFER_CYC), .BANK_W(BANK_W), .WORD_W(WORD_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .mode_serial(mode_serial), .req_valid(req_valid),
    .req_ready(req_ready), .req_line(req_line), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_last(rsp_last)
);

// File: tb/test_ilv_line_fetch.sv
// Bench: behavioural reference compared on every clock, plus scenario checks.
module test_ilv_line_fetch;
    localparam int LW = 14;
    localparam int NB = 4;
    localparam int A  = 4;
    localparam int C  = 24;
    localparam int X  = 4;
    localparam int WW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_serial = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [LW-1:0] req_line = '0;
    logic          rsp_valid;
    logic [WW-1:0] rsp_data;
    logic          rsp_last;

    int total = 0;
    int fails = 0;
    int cyc = 0;

    // reference model state
    bit            m_busy = 1'b0;
    int            m_acc = 0;
    bit            m_mode = 1'b0;
    logic [LW-1:0] m_line = '0;

    ilv_line_fetch i_ilv_line_fetch (
        .clk(clk), .rst_n(rst_n), .mode_serial(mode_serial), .req_valid(req_valid),
        .req_ready(req_ready), .req_line(req_line), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_last(rsp_last)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    function automatic int edge_of(input int k, input bit ser);
        return ser ? (k + 1) * (A + C + X) : A + C + (k + 1) * X;
    endfunction

    function automatic logic [WW-1:0] word_of(input logic [LW-1:0] line, input int k);
        logic [15:0] wa;
        wa = 16'(line) * 16'd4 + 16'(k);
        return {~wa, wa};
    endfunction

    // Reference model: per-cycle expected outputs, compared away from the clock edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0;
        end else begin
            int off;
            bit ev;
            int k;
            off = cyc - m_acc;
            if (m_busy && off == edge_of(NB - 1, m_mode)) m_busy = 1'b0;
            ev = 1'b0;
            k = 0;
            if (m_busy) begin
                for (int j = 0; j < NB; j++)
                    if (off == edge_of(j, m_mode) - 1) begin ev = 1'b1; k = j; end
            end
            chk(req_ready == !m_busy, "R2", "req_ready", req_ready, !m_busy);
            chk(rsp_valid == ev, m_mode ? "R5" : "R4", "rsp_valid", rsp_valid, ev);
            chk(rsp_last == (ev && k == NB - 1), "R6", "rsp_last", rsp_last, ev && k == NB - 1);
            if (ev) chk(rsp_data == word_of(m_line, k), "R3", "rsp_data", rsp_data, word_of(m_line, k));
            if (!m_busy && req_valid) begin
                m_busy = 1'b1;
                m_acc  = cyc + 1;
                m_mode = mode_serial;
                m_line = req_line;
            end
        end
    end

    task automatic summary();
        $display("  %0d/%0d checks passed", total - fails, total);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL R2 watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    task automatic wait_accept(output int acc);
        forever begin
            @(negedge clk);
            if (req_ready && req_valid) break;
        end
        @(posedge clk);
        #1 acc = cyc;
    endtask

    task automatic wait_last(input int acc, output int lat, output int pulses);
        pulses = 0;
        forever begin
            @(negedge clk);
            if (rsp_valid) pulses++;
            if (rsp_last) break;
        end
        lat = cyc + 1 - acc;
    endtask

    task automatic one_req(input logic [LW-1:0] line, input bit ser, input bit wiggle);
        int acc, lat, n;
        @(posedge clk);
        #1 req_valid = 1'b1; req_line = line; mode_serial = ser;
        wait_accept(acc);
        req_valid = 1'b0;
        if (wiggle) begin mode_serial = ~ser; req_line = ~line; end
        wait_last(acc, lat, n);
        if (wiggle) chk(lat == (ser ? 128 : 44), "R7", "latency after mode change", lat, ser ? 128 : 44);
        else if (ser) chk(lat == 128, "R5", "serial refill clocks", lat, 128);
        else chk(lat == 44, "R4", "interleaved refill clocks", lat, 44);
        chk(n == NB, "R6", "word pulses", n, NB);
    endtask

    initial begin
        int a1, a2, lat, n;
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            chk(req_ready && !rsp_valid && !rsp_last, "R1", "outputs in reset",
                {req_ready, rsp_valid, rsp_last}, 3'b100);
        end
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !rsp_last, "R1", "outputs after reset",
            {req_ready, rsp_valid, rsp_last}, 3'b100);

        one_req(14'h0005, 1'b0, 1'b0);
        one_req(14'h3FFF, 1'b1, 1'b0);
        one_req(14'h1234, 1'b0, 1'b1);   // R7, R8: mode and line changed mid-refill
        one_req(14'h0ABC, 1'b1, 1'b1);   // R7, R8 in serial mode
        one_req(14'h0000, 1'b0, 1'b0);

        // R9: request held valid during a refill is taken back-to-back
        @(posedge clk);
        #1 req_valid = 1'b1; req_line = 14'h0777; mode_serial = 1'b0;
        wait_accept(a1);
        req_line = 14'h2222;
        wait_last(a1, lat, n);
        chk(lat == 44, "R4", "first of pair clocks", lat, 44);
        wait_accept(a2);
        req_valid = 1'b0;
        chk(a2 - a1 == 45, "R9", "back-to-back acceptance gap", a2 - a1, 45);
        wait_last(a2, lat, n);
        chk(n == NB, "R6", "second of pair pulses", n, NB);

        // idle: no response without a request
        repeat (20) @(negedge clk);
        chk(req_ready && !rsp_valid, "R2", "idle outputs", {req_ready, rsp_valid}, 2'b10);

        summary();
        $finish;
    end
endmodule